// File: doc/BRIEF.md
# Prescaled Up/Down Event Timer

This block is a 16-bit counter behind a small 32-bit register bus. Software picks the count direction, a power-of-two clock divider, a counter source, whether the timer halts itself on its first wrap, and a reload limit held in a limit register. Start and stop are issued through a command register. The counter value can be read or overwritten at any time.

In down mode the counter goes below zero by reloading the limit, and this raises an underflow flag. In up mode it wraps from the limit back to zero and raises an overflow flag. Software can set or clear the flags through dedicated write-only registers. Each flag can be masked, and the unmasked flags are combined onto one level-sensitive interrupt line. A typical single-delay use is: stop the timer, load the delay into the counter, select down mode with the halt-on-wrap bit, and start it. The interrupt then fires once when the delay runs out.

Top module: `tick_timer`

## Requirements
- R1: After reset, CTRL, IEN, IF, CNT, STATUS and CMD read 0, TOP reads 0x0000FFFF, and `irq` is 0.
- R2: The byte offsets are CTRL 0x00, CMD 0x04, STATUS 0x08 (bit 0 = running), IEN 0x0C, IF 0x10, IFS 0x14, IFC 0x18, TOP 0x1C and CNT 0x24. CTRL keeps mode in [1:0], halt-on-wrap in bit 4, counter source in [17:16] and divider code in [27:24]. Unused bits and unmapped offsets read 0, and TOP, IEN and CNT read back only their implemented low bits.
- R3: Writing CMD with bit 0 set starts the timer and with bit 1 set stops it. When both bits are set, stop wins. CMD always reads 0.
- R4: With divider code c, source 0 and the timer running, the counter steps once every 2^c cycles. The first step comes 2^c clock edges after the edge that commits the start write.
- R5: When mode is not 1, the counter counts up. A step taken at the TOP value goes to 0 and sets IF bit 0 (overflow).
- R6: When mode is 1, the counter counts down. A step taken at 0 reloads TOP and sets IF bit 1 (underflow).
- R7: When halt-on-wrap (CTRL bit 4) is set, the step that wraps the counter also stops the timer. The counter then holds its post-wrap value.
- R8: A write to CNT loads the counter. While the timer is stopped, the counter holds its value.
- R9: A nonzero counter source field keeps the counter from advancing even while the timer is running.
- R10: Writing 1s to IFS sets those IF bits, and writing 1s to IFC clears them. A hardware wrap event in the same cycle as an IFC write to its bit leaves that bit set.
- R11: `irq` is high exactly when some IF bit and the matching IEN bit are both 1.
- R12: IF is read-only, so writes to offset 0x10 leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWe | input | 1 | Register write strobe, one cycle per write |
| regAddr | input | ADDR_W | Byte offset for the write or read |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for regAddr (combinational) |
| irq | output | 1 | Level interrupt: OR of IF AND IEN |

## Verification
The bench builds the block with its default parameters: a 16-bit counter, an 8-bit offset bus and a 4-bit divider code. Small TOP values make complete up and down wrap sequences short enough to check at every cycle. Divider codes 0 to 3 are swept against an arithmetic model of the step cycle. The counter is also launched from a one-count delay, so that the underflow lands in the same cycle as a flag-clear write, which exercises the hardware-over-clear priority.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int CODE_W = 4;
  localparam int NFLAG  = 2;

  localparam int OFF_CTRL = 'h00;
  localparam int OFF_CMD  = 'h04;
  localparam int OFF_STAT = 'h08;
  localparam int OFF_IEN  = 'h0C;
  localparam int OFF_IF   = 'h10;
  localparam int OFF_IFS  = 'h14;
  localparam int OFF_IFC  = 'h18;
  localparam int OFF_TOP  = 'h1C;
  localparam int OFF_CNT  = 'h24;

  typedef struct packed {
    logic [CODE_W-1:0] presc;
    logic [1:0]        clkSrc;
    logic              oneShot;
    logic [1:0]        mode;
  } tmrCfg_t;

  typedef struct packed {
    logic start;
    logic stop;
    logic load;
  } tmrStrobe_t;

endpackage

// File: rtl/timer_prescaler.sv
module timer_prescaler
  import timer_pkg::*;
#(
  parameter int CW = CODE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          enable,
  input  logic          restart,
  input  logic [CW-1:0] code,
  output logic          tick
);

  localparam int DIV_W = (1 << CW) - 1;

  logic [DIV_W-1:0] pCnt;
  logic [DIV_W-1:0] mask;

  always_comb begin
    mask = ~({DIV_W{1'b1}} << code);
    tick = enable && ((pCnt & mask) == mask);
  end

  always_ff @(posedge clk) begin
    if (!rstN || restart) pCnt <= '0;
    else if (enable)      pCnt <= pCnt + 1'b1;
  end

endmodule

// File: rtl/timer_datapath.sv
module timer_datapath
  import timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  tmrCfg_t          cfg,
  input  logic [CNT_W-1:0] top,
  input  tmrStrobe_t       strobe,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             ovfEvt,
  output logic             unfEvt
);

  logic tick;
  logic countDown;
  logic srcOk;
  logic atTop;
  logic atZero;
  logic [CNT_W-1:0] cntNext;

  assign srcOk = (cfg.clkSrc == 2'd0);

  timer_prescaler #(.CW(CODE_W)) u_presc (
    .clk    (clk),
    .rstN   (rstN),
    .enable (running && srcOk),
    .restart(strobe.start),
    .code   (cfg.presc),
    .tick   (tick)
  );

  always_comb begin
    countDown = (cfg.mode == 2'd1);
    atTop     = (cnt == top);
    atZero    = (cnt == '0);
    ovfEvt    = tick && !strobe.load && !countDown && atTop;
    unfEvt    = tick && !strobe.load && countDown && atZero;
    cntNext   = cnt;
    if (strobe.load) begin
      cntNext = loadVal;
    end else if (tick) begin
      if (countDown) cntNext = atZero ? top : cnt - 1'b1;
      else           cntNext = atTop ? '0 : cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      running <= 1'b0;
    end else begin
      cnt <= cntNext;
      if (strobe.stop)                                running <= 1'b0;
      else if (strobe.start)                          running <= 1'b1;
      else if (cfg.oneShot && (ovfEvt || unfEvt))     running <= 1'b0;
    end
  end

endmodule

// File: rtl/timer_ctrl.sv
module timer_ctrl
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              running,
  input  logic              ovfEvt,
  input  logic              unfEvt,
  output tmrCfg_t           cfg,
  output logic [CNT_W-1:0]  top,
  output tmrStrobe_t        strobe,
  output logic [CNT_W-1:0]  loadVal,
  output logic [NFLAG-1:0]  flags,
  output logic [NFLAG-1:0]  ien,
  output logic              irq
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int off);
    return a == ADDR_W'(off);
  endfunction

  logic [NFLAG-1:0] setBits;
  logic [NFLAG-1:0] clrBits;
  logic [NFLAG-1:0] hwBits;
  logic [NFLAG-1:0] flagsNext;
  logic unusedWdata;

  assign unusedWdata = &{1'b0, regWdata[31:28], regWdata[23:18]};
  assign loadVal     = regWdata[CNT_W-1:0];

  always_comb begin
    strobe.start = regWe && hit(regAddr, OFF_CMD) && regWdata[0];
    strobe.stop  = regWe && hit(regAddr, OFF_CMD) && regWdata[1];
    strobe.load  = regWe && hit(regAddr, OFF_CNT);
    setBits   = (regWe && hit(regAddr, OFF_IFS)) ? regWdata[NFLAG-1:0] : '0;
    clrBits   = (regWe && hit(regAddr, OFF_IFC)) ? regWdata[NFLAG-1:0] : '0;
    hwBits    = {unfEvt, ovfEvt};
    flagsNext = ((flags | setBits) & ~clrBits) | hwBits;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg   <= '0;
      top   <= '1;
      ien   <= '0;
      flags <= '0;
    end else begin
      flags <= flagsNext;
      if (regWe && hit(regAddr, OFF_CTRL)) begin
        cfg.presc   <= regWdata[27:24];
        cfg.clkSrc  <= regWdata[17:16];
        cfg.oneShot <= regWdata[4];
        cfg.mode    <= regWdata[1:0];
      end
      if (regWe && hit(regAddr, OFF_TOP)) top <= regWdata[CNT_W-1:0];
      if (regWe && hit(regAddr, OFF_IEN)) ien <= regWdata[NFLAG-1:0];
    end
  end

  always_comb begin
    regRdata = '0;
    if (hit(regAddr, OFF_CTRL)) begin
      regRdata[27:24] = cfg.presc;
      regRdata[17:16] = cfg.clkSrc;
      regRdata[4]     = cfg.oneShot;
      regRdata[1:0]   = cfg.mode;
    end else if (hit(regAddr, OFF_STAT)) begin
      regRdata[0] = running;
    end else if (hit(regAddr, OFF_IEN)) begin
      regRdata[NFLAG-1:0] = ien;
    end else if (hit(regAddr, OFF_IF)) begin
      regRdata[NFLAG-1:0] = flags;
    end else if (hit(regAddr, OFF_TOP)) begin
      regRdata[CNT_W-1:0] = top;
    end else if (hit(regAddr, OFF_CNT)) begin
      regRdata[CNT_W-1:0] = cnt;
    end
  end

  assign irq = |(flags & ien);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  output logic              irq
);

  tmrCfg_t          cfg;
  tmrStrobe_t       strobe;
  logic [CNT_W-1:0] top;
  logic [CNT_W-1:0] loadVal;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             ovfEvt;
  logic             unfEvt;
  logic [NFLAG-1:0] flags;
  logic [NFLAG-1:0] ien;

  timer_ctrl #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .regWe   (regWe),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .cnt     (cnt),
    .running (running),
    .ovfEvt  (ovfEvt),
    .unfEvt  (unfEvt),
    .cfg     (cfg),
    .top     (top),
    .strobe  (strobe),
    .loadVal (loadVal),
    .flags   (flags),
    .ien     (ien),
    .irq     (irq)
  );

  timer_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .cfg    (cfg),
    .top    (top),
    .strobe (strobe),
    .loadVal(loadVal),
    .cnt    (cnt),
    .running(running),
    .ovfEvt (ovfEvt),
    .unfEvt (unfEvt)
  );

endmodule

// File: rtl/timer_checker.sv
module timer_checker
  import timer_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              regWe,
  input logic [ADDR_W-1:0] regAddr,
  input logic              wBit0,
  input logic              wBit1,
  input logic [31:0]       regRdata,
  input logic              irq,
  input logic [NFLAG-1:0]  ien,
  input logic [NFLAG-1:0]  flags,
  input logic [CNT_W-1:0]  cnt,
  input logic              running,
  input logic              oneShot,
  input logic              ovfEvt,
  input logic              unfEvt
);

  logic cmdWr, cntWr, ifcWr;
  assign cmdWr = regWe && (regAddr == ADDR_W'(OFF_CMD));
  assign cntWr = regWe && (regAddr == ADDR_W'(OFF_CNT));
  assign ifcWr = regWe && (regAddr == ADDR_W'(OFF_IFC));

  // R3: a stop command always halts the timer
  p_stop_wins_r3: assert property (@(posedge clk) disable iff (!rstN)
    cmdWr && wBit1 |=> !running);

  // R3: the command register never returns data
  p_cmd_reads_zero_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(OFF_CMD)) |-> (regRdata == 32'd0));

  // R7: a wrap in halt-on-wrap mode stops the timer
  p_oneshot_halt_r7: assert property (@(posedge clk) disable iff (!rstN)
    running && oneShot && (ovfEvt || unfEvt) && !(cmdWr && wBit0) |=> !running);

  // R8: a stopped counter without a load keeps its value
  p_hold_stopped_r8: assert property (@(posedge clk) disable iff (!rstN)
    !running && !cntWr |=> $stable(cnt));

  // R10: hardware events land in the flags even against a clear
  p_unf_sets_r10: assert property (@(posedge clk) disable iff (!rstN)
    unfEvt |=> flags[1]);
  p_ovf_sets_r10: assert property (@(posedge clk) disable iff (!rstN)
    ovfEvt |=> flags[0]);

  // R10: a clear with no competing event removes the flag
  p_clear_r10: assert property (@(posedge clk) disable iff (!rstN)
    ifcWr && wBit1 && !unfEvt |=> !flags[1]);

  // R11: fully masked flags never raise the line
  p_masked_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ien == '0) |-> !irq);

endmodule

bind tick_timer timer_checker #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .regWe   (regWe),
  .regAddr (regAddr),
  .wBit0   (regWdata[0]),
  .wBit1   (regWdata[1]),
  .regRdata(regRdata),
  .irq     (irq),
  .ien     (ien),
  .flags   (flags),
  .cnt     (cnt),
  .running (running),
  .oneShot (cfg.oneShot),
  .ovfEvt  (ovfEvt),
  .unfEvt  (unfEvt)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
  localparam int CNT_W  = 16;
  localparam int ADDR_W = 8;

  localparam logic [7:0] A_CTRL = 8'h00, A_CMD = 8'h04, A_STAT = 8'h08,
                         A_IEN = 8'h0C, A_IF = 8'h10, A_IFS = 8'h14,
                         A_IFC = 8'h18, A_TOP = 8'h1C, A_CNT = 8'h24;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWe = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tick_timer #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWe = 1'b0; regWdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic rdChk(input string tag, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(tag, v, exp);
  endtask

  task automatic setup(input logic [31:0] topV, input logic [31:0] cntV, input logic [31:0] ctrlV);
    wr(A_CMD, 32'h2);
    wr(A_IFC, 32'h3);
    wr(A_TOP, topV);
    wr(A_CNT, cntV);
    wr(A_CTRL, ctrlV);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rdChk("R1 ctrl", A_CTRL, 32'h0);
    rdChk("R1 cmd", A_CMD, 32'h0);
    rdChk("R1 status", A_STAT, 32'h0);
    rdChk("R1 ien", A_IEN, 32'h0);
    rdChk("R1 if", A_IF, 32'h0);
    rdChk("R1 top", A_TOP, 32'h0000FFFF);
    rdChk("R1 cnt", A_CNT, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    // R2 field placement and readback masking
    wr(A_CTRL, 32'hFFFF_FFFF);
    rdChk("R2 ctrl fields", A_CTRL, 32'h0F03_0013);
    wr(A_TOP, 32'hABCD_1234);
    rdChk("R2 top width", A_TOP, 32'h0000_1234);
    wr(A_IEN, 32'hFFFF_FFFF);
    rdChk("R2 ien width", A_IEN, 32'h3);
    wr(A_IEN, 32'h0);
    rdChk("R2 unmapped", 8'h20, 32'h0);
    wr(A_CTRL, 32'h0);

    // R4 divider sweep, codes 0..3
    for (int c = 0; c < 4; c++) begin
      setup(32'hFFFF, 32'h0, 32'(c) << 24);
      wr(A_CMD, 32'h1);
      for (int n = 1; n <= 20; n++) begin
        @(negedge clk);
        rdChk($sformatf("R4 code %0d step %0d", c, n), A_CNT, 32'(n >> c));
      end
    end

    // R5 up wrap at TOP=4
    setup(32'd4, 32'd0, 32'h0);
    wr(A_CMD, 32'h1);
    for (int n = 1; n <= 12; n++) begin
      @(negedge clk);
      rdChk($sformatf("R5 cnt n=%0d", n), A_CNT, 32'(n % 5));
      rdChk($sformatf("R5 ovf n=%0d", n), A_IF, (n >= 5) ? 32'h1 : 32'h0);
    end

    // R5 mode code 2 also counts up
    setup(32'hFFFF, 32'd0, 32'h2);
    wr(A_CMD, 32'h1);
    repeat (3) @(negedge clk);
    rdChk("R5 mode2 up", A_CNT, 32'd3);

    // R6 down wrap at TOP=5 from 3
    setup(32'd5, 32'd3, 32'h1);
    wr(A_CMD, 32'h1);
    for (int n = 1; n <= 14; n++) begin
      @(negedge clk);
      rdChk($sformatf("R6 cnt n=%0d", n), A_CNT, 32'((((3 - n) % 6) + 6) % 6));
      rdChk($sformatf("R6 unf n=%0d", n), A_IF, (n >= 4) ? 32'h2 : 32'h0);
    end

    // R7 halt-on-wrap, down
    setup(32'd7, 32'd2, 32'h11);
    wr(A_CMD, 32'h1);
    for (int n = 1; n <= 6; n++) begin
      @(negedge clk);
      rdChk($sformatf("R7 down cnt n=%0d", n), A_CNT, (n == 1) ? 32'd1 : (n == 2) ? 32'd0 : 32'd7);
      rdChk($sformatf("R7 down run n=%0d", n), A_STAT, (n < 3) ? 32'h1 : 32'h0);
    end

    // R7 halt-on-wrap, up
    setup(32'd3, 32'd2, 32'h10);
    wr(A_CMD, 32'h1);
    repeat (5) @(negedge clk);
    rdChk("R7 up cnt", A_CNT, 32'd0);
    rdChk("R7 up run", A_STAT, 32'h0);
    rdChk("R7 up ovf", A_IF, 32'h1);

    // R8 load and hold while stopped
    wr(A_CMD, 32'h2);
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'h1234);
    rdChk("R8 load", A_CNT, 32'h1234);
    repeat (5) @(negedge clk);
    rdChk("R8 hold", A_CNT, 32'h1234);

    // R3 stop priority and command readback
    wr(A_CMD, 32'h3);
    rdChk("R3 both bits", A_STAT, 32'h0);
    rdChk("R3 cmd zero", A_CMD, 32'h0);
    wr(A_CMD, 32'h1);
    rdChk("R3 start", A_STAT, 32'h1);
    wr(A_CMD, 32'h2);
    rdChk("R3 stop", A_STAT, 32'h0);
    rd(A_CNT, v);
    repeat (4) @(negedge clk);
    rdChk("R3 stopped holds", A_CNT, v);

    // R9 nonzero source blocks counting
    setup(32'hFFFF, 32'd0, 32'h0001_0000);
    wr(A_CMD, 32'h1);
    repeat (8) @(negedge clk);
    rdChk("R9 cnt", A_CNT, 32'd0);
    rdChk("R9 running", A_STAT, 32'h1);
    wr(A_CMD, 32'h2);

    // R10 software set and clear
    wr(A_IFC, 32'h3);
    wr(A_IFS, 32'h3);
    rdChk("R10 set", A_IF, 32'h3);
    wr(A_IFC, 32'h1);
    rdChk("R10 clear", A_IF, 32'h2);

    // R10 underflow coincides with clear
    setup(32'd9, 32'd1, 32'h1);
    wr(A_CMD, 32'h1);
    wr(A_IFC, 32'h2);
    rdChk("R10 hw over clear", A_IF, 32'h2);
    wr(A_CMD, 32'h2);
    wr(A_IFC, 32'h2);
    rdChk("R10 clear after", A_IF, 32'h0);

    // R12 IF read-only
    wr(A_IFS, 32'h1);
    wr(A_IF, 32'h0);
    rdChk("R12 write zero ignored", A_IF, 32'h1);
    wr(A_IF, 32'h3);
    rdChk("R12 write ones ignored", A_IF, 32'h1);

    // R11 masking
    wr(A_IEN, 32'h0);
    #1 chk("R11 ien0", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h2);
    #1 chk("R11 other mask", {31'b0, irq}, 32'h0);
    wr(A_IEN, 32'h1);
    #1 chk("R11 match", {31'b0, irq}, 32'h1);
    wr(A_IFC, 32'h1);
    #1 chk("R11 cleared", {31'b0, irq}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule